// File: doc/BRIEF.md
# Deep Sleep Wake Source Controller

This block decides when a sleeping chip may be woken and keeps a record of every event that could have woken it. It watches a vector of general-purpose pins, two serial-controller pins and one external interrupt pin for any change of level. It watches two debug power-up request bits for a rising edge. It also takes three one-cycle pulses from a sleep timer (compare A, compare B, wrap) and a one-cycle pulse that stands for software writing the core-wake bit.

Each detected event sets a sticky bit in a record register. This happens at all times, whether the chip runs or sleeps, so several sources can be captured before wakeup completes. Software clears record bits by writing ones. A mask register selects the sources allowed to wake the chip. The sleep-level input then narrows that choice to the sources that can work at the current depth.

Level 0 keeps the core powered and holds the peripherals in reset. Level 1 powers the core down but keeps the sleep timer running. Level 2 is level 1 with the timer stopped. The wake request to the power sequencer is raised only while the sleeping indication is high.

Top module: `wake_src_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, the record reads 0, the mask reads all ones (0x3FF) and wake_req is low.
- R2: The first clock edge after reset only captures the input levels. A pin that is already high, or a request bit that is already set, at that edge records no event.
- R3: A change of level in either direction sets a record bit one clock edge later. Record bit 0 is set by a change on any gpio_in bit, bit 1 by sc1_pin, bit 2 by sc2_pin and bit 3 by irq_pin.
- R4: A rising edge of dbg_pwrup_req sets record bit 4 and a rising edge of sys_pwrup_req sets bit 5, one edge later. Falling edges record nothing.
- R5: A pulse on tmr_cmp_a, tmr_cmp_b or tmr_wrap sets record bit 6, 7 or 8 respectively. A pulse on core_wake_set sets bit 9. Each is visible one edge later.
- R6: Events are recorded whatever the values of sleeping and sleep_level, and record bits from different sources accumulate.
- R7: Record bits are sticky. A cycle with clr_we high clears exactly the record bits where clr_wdata is 1; bits written 0 keep their value.
- R8: If an event and a clear of the same record bit fall in the same cycle, the bit ends up set.
- R9: A cycle with mask_we high loads mask_wdata into the mask, which is readable on wake_mask. The mask uses the same bit positions as the record.
- R10: wake_req is high in the same cycle exactly when sleeping is high and at least one record bit is set in both the mask and the eligibility set of the current level. When sleeping is low, wake_req is low.
- R11: Record bits 0 to 5 are eligible at every level. Bits 6 to 8 are eligible only at sleep_level 1. Bit 9 is eligible only at sleep_level 0. sleep_level 3 behaves like level 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_in | input | GPIO_W | General-purpose pin levels |
| sc1_pin | input | 1 | Serial controller 1 wake pin level |
| sc2_pin | input | 1 | Serial controller 2 wake pin level |
| irq_pin | input | 1 | External interrupt pin level |
| dbg_pwrup_req | input | 1 | Debug power-up request bit |
| sys_pwrup_req | input | 1 | System power-up request bit |
| tmr_cmp_a | input | 1 | Sleep timer compare A pulse |
| tmr_cmp_b | input | 1 | Sleep timer compare B pulse |
| tmr_wrap | input | 1 | Sleep timer wrap pulse |
| core_wake_set | input | 1 | Pulse: software wrote 1 to the core-wake bit |
| sleep_level | input | 2 | Current deep sleep level (0, 1, 2; 3 acts as 2) |
| sleeping | input | 1 | High while the chip is in deep sleep |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 10 | New mask value |
| clr_we | input | 1 | Record clear strobe |
| clr_wdata | input | 10 | Write-one-to-clear pattern for the record |
| wake_req | output | 1 | Wake request to the power sequencer |
| event_rec | output | 10 | Sticky event record |
| wake_mask | output | 10 | Current mask register |

## Verification
Every event source passes through exactly one register before it reaches the record. Pins and request bits are compared with their copies from the previous edge, and a change driven between two edges shows in event_rec right after the next edge. The bench therefore drives at a falling edge and compares at the following falling edge. Mask and clear writes follow the same one-edge timing. wake_req has no register of its own, so level, sleeping and mask changes are compared in the half cycle after they are driven, before any further edge. The collision case drives a pin change and a clear of the same bit into the same cycle and reads the record one edge later.

// File: rtl/wake_src_pkg.sv
package wake_src_pkg;

    localparam int NUM_SRC   = 10;
    localparam int IDX_GPIO  = 0;
    localparam int IDX_SC1   = 1;
    localparam int IDX_SC2   = 2;
    localparam int IDX_IRQ   = 3;
    localparam int IDX_DBG   = 4;
    localparam int IDX_SYS   = 5;
    localparam int IDX_CMPA  = 6;
    localparam int IDX_CMPB  = 7;
    localparam int IDX_WRAP  = 8;
    localparam int IDX_CORE  = 9;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        LVL_EMULATED = 2'd0,
        LVL_TIMED    = 2'd1,
        LVL_DEEPEST  = 2'd2,
        LVL_SPARE    = 2'd3
    } sleep_lvl_e;

    // Sources usable at any depth: pin changes and debug requests
    localparam src_vec_t ALWAYS_SET = src_vec_t'(10'h03F);
    localparam src_vec_t TIMER_SET  = src_vec_t'(10'h1C0);
    localparam src_vec_t CORE_SET   = src_vec_t'(10'h200);

endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
    parameter int W         = 4,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    output logic [W-1:0] hit
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         primed;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [W-1:0] raw_hit;

    generate
        if (RISE_ONLY) begin : g_rise
            assign raw_hit = lvl_in & ~st_q.prev;
        end else begin : g_any
            assign raw_hit = lvl_in ^ st_q.prev;
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.prev   = lvl_in;
        st_d.primed = 1'b1;
        hit         = st_q.primed ? raw_hit : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wake_eligibility.sv
module wake_eligibility
    import wake_src_pkg::*;
(
    input  logic [1:0] level,
    output src_vec_t   eligible
);

    sleep_lvl_e lvl;

    always_comb begin
        lvl = sleep_lvl_e'(level);
        unique case (lvl)
            LVL_EMULATED: eligible = ALWAYS_SET | CORE_SET;
            LVL_TIMED:    eligible = ALWAYS_SET | TIMER_SET;
            LVL_DEEPEST:  eligible = ALWAYS_SET;
            LVL_SPARE:    eligible = ALWAYS_SET;
            default:      eligible = ALWAYS_SET;
        endcase
    end

endmodule

// File: rtl/wake_record.sv
module wake_record
    import wake_src_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t events,
    input  logic     mask_we,
    input  src_vec_t mask_wdata,
    input  logic     clr_we,
    input  src_vec_t clr_wdata,
    output src_vec_t rec,
    output src_vec_t mask
);

    typedef struct packed {
        src_vec_t rec;
        src_vec_t mask;
    } rec_state_t;

    rec_state_t st_d, st_q;
    src_vec_t   clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = clr_we ? clr_wdata : '0;
        // Clear first, then set: a simultaneous event keeps its bit
        st_d.rec = (st_q.rec & ~clr_bits) | events;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rec  <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rec  = st_q.rec;
    assign mask = st_q.mask;

endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
    import wake_src_pkg::*;
#(
    parameter int GPIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] gpio_in,
    input  logic              sc1_pin,
    input  logic              sc2_pin,
    input  logic              irq_pin,
    input  logic              dbg_pwrup_req,
    input  logic              sys_pwrup_req,
    input  logic              tmr_cmp_a,
    input  logic              tmr_cmp_b,
    input  logic              tmr_wrap,
    input  logic              core_wake_set,
    input  logic [1:0]        sleep_level,
    input  logic              sleeping,
    input  logic              mask_we,
    input  logic [9:0]        mask_wdata,
    input  logic              clr_we,
    input  logic [9:0]        clr_wdata,
    output logic              wake_req,
    output logic [9:0]        event_rec,
    output logic [9:0]        wake_mask
);

    localparam int PIN_W = GPIO_W + 3;

    logic [PIN_W-1:0] pin_lvl;
    logic [PIN_W-1:0] pin_hit;
    logic [1:0]       req_hit;
    src_vec_t         events;
    src_vec_t         eligible;
    src_vec_t         rec;
    src_vec_t         mask;

    assign pin_lvl = {irq_pin, sc2_pin, sc1_pin, gpio_in};

    wake_edge_det #(.W(PIN_W), .RISE_ONLY(1'b0)) u_pin_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (pin_lvl),
        .hit    (pin_hit)
    );

    wake_edge_det #(.W(2), .RISE_ONLY(1'b1)) u_req_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in ({sys_pwrup_req, dbg_pwrup_req}),
        .hit    (req_hit)
    );

    always_comb begin
        events            = '0;
        events[IDX_GPIO]  = |pin_hit[GPIO_W-1:0];
        events[IDX_SC1]   = pin_hit[GPIO_W];
        events[IDX_SC2]   = pin_hit[GPIO_W+1];
        events[IDX_IRQ]   = pin_hit[GPIO_W+2];
        events[IDX_DBG]   = req_hit[0];
        events[IDX_SYS]   = req_hit[1];
        events[IDX_CMPA]  = tmr_cmp_a;
        events[IDX_CMPB]  = tmr_cmp_b;
        events[IDX_WRAP]  = tmr_wrap;
        events[IDX_CORE]  = core_wake_set;
    end

    wake_eligibility u_elig (
        .level    (sleep_level),
        .eligible (eligible)
    );

    wake_record u_rec (
        .clk        (clk),
        .rst_n      (rst_n),
        .events     (events),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .clr_we     (clr_we),
        .clr_wdata  (clr_wdata),
        .rec        (rec),
        .mask       (mask)
    );

    assign wake_req  = sleeping & (|(rec & mask & eligible));
    assign event_rec = rec;
    assign wake_mask = mask;

endmodule

// File: rtl/wake_src_checker.sv
module wake_src_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_pin,
    input logic       dbg_pwrup_req,
    input logic [1:0] sleep_level,
    input logic       sleeping,
    input logic       clr_we,
    input logic [9:0] clr_wdata,
    input logic [9:0] mask_q_obs,
    input logic       wake_req,
    input logic [9:0] event_rec
);

    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    // R7: a set record bit survives unless that bit was written with a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |=> ((($past(event_rec) & ~($past(clr_we) ? $past(clr_wdata) : 10'h000))
                     & ~event_rec) == 10'h000));

    // R10: no wake request while running
    a_r10_awake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sleeping |-> !wake_req);

    // R11: timer and core bits cannot wake at levels 2 and 3
    a_r11_deep_no_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_level[1] && ((event_rec & mask_q_obs & 10'h03F) == 10'h000)) |-> !wake_req);

    // R11: core-wake bit alone cannot wake outside level 0
    a_r11_core_emulated_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((sleep_level != 2'd0) && ((event_rec & mask_q_obs & 10'h1FF) == 10'h000)) |-> !wake_req);

    // R4, R8: a debug rising edge is recorded on the next edge, even against a clear
    a_r4_dbg_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $rose(dbg_pwrup_req)) |=> event_rec[4]);

    // R3, R8: any irq pin change is recorded on the next edge
    a_r3_irq_change: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$stable(irq_pin)) |=> event_rec[3]);

endmodule

bind wake_src_ctrl wake_src_checker u_wake_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_pin       (irq_pin),
    .dbg_pwrup_req (dbg_pwrup_req),
    .sleep_level   (sleep_level),
    .sleeping      (sleeping),
    .clr_we        (clr_we),
    .clr_wdata     (clr_wdata),
    .mask_q_obs    (wake_mask),
    .wake_req      (wake_req),
    .event_rec     (event_rec)
);

// File: tb/wake_src_ctrl_test.sv
`timescale 1ns/1ps
module wake_src_ctrl_test;

    localparam int GPIO_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [GPIO_W-1:0] gpio_in = '0;
    logic              sc1_pin = 1'b0;
    logic              sc2_pin = 1'b0;
    logic              irq_pin = 1'b0;
    logic              dbg_pwrup_req = 1'b0;
    logic              sys_pwrup_req = 1'b0;
    logic              tmr_cmp_a = 1'b0;
    logic              tmr_cmp_b = 1'b0;
    logic              tmr_wrap = 1'b0;
    logic              core_wake_set = 1'b0;
    logic [1:0]        sleep_level = 2'd0;
    logic              sleeping = 1'b0;
    logic              mask_we = 1'b0;
    logic [9:0]        mask_wdata = '0;
    logic              clr_we = 1'b0;
    logic [9:0]        clr_wdata = '0;
    logic              wake_req;
    logic [9:0]        event_rec;
    logic [9:0]        wake_mask;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wake_src_ctrl #(.GPIO_W(GPIO_W)) uut (
        .clk (clk), .rst_n (rst_n), .gpio_in (gpio_in),
        .sc1_pin (sc1_pin), .sc2_pin (sc2_pin), .irq_pin (irq_pin),
        .dbg_pwrup_req (dbg_pwrup_req), .sys_pwrup_req (sys_pwrup_req),
        .tmr_cmp_a (tmr_cmp_a), .tmr_cmp_b (tmr_cmp_b), .tmr_wrap (tmr_wrap),
        .core_wake_set (core_wake_set), .sleep_level (sleep_level),
        .sleeping (sleeping), .mask_we (mask_we), .mask_wdata (mask_wdata),
        .clr_we (clr_we), .clr_wdata (clr_wdata), .wake_req (wake_req),
        .event_rec (event_rec), .wake_mask (wake_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_wdata = 10'h3FF;
        step();
        clr_we = 1'b0; clr_wdata = '0;
    endtask

    task automatic t_reset();
        irq_pin = 1'b1; gpio_in = 8'h5A; dbg_pwrup_req = 1'b1;
        repeat (3) step();
        check("R1 rec in reset", event_rec, 10'h000);
        check("R1 mask in reset", wake_mask, 10'h3FF);
        check("R1 wake in reset", wake_req, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 rec after release", event_rec, 10'h000);
        step(); step();
        check("R2 no event from held levels", event_rec, 10'h000);
        dbg_pwrup_req = 1'b0;
        step();
        check("R4 falling edge ignored", event_rec, 10'h000);
    endtask

    task automatic t_pins();
        gpio_in[3] = ~gpio_in[3];
        step();
        check("R3 gpio change", event_rec, 10'h001);
        sc1_pin = 1'b1;
        step();
        check("R3 sc1 rise", event_rec, 10'h003);
        sc2_pin = 1'b1;
        step();
        check("R3 sc2 rise, R6 accumulate", event_rec, 10'h007);
        irq_pin = 1'b0;
        step();
        check("R3 irq fall", event_rec, 10'h00F);
        clr_we = 1'b1; clr_wdata = 10'h002;
        step();
        clr_we = 1'b0; clr_wdata = '0;
        check("R7 partial clear", event_rec, 10'h00D);
        clear_all();
        check("R7 full clear", event_rec, 10'h000);
        sc1_pin = 1'b0;
        step();
        check("R3 sc1 fall", event_rec, 10'h002);
        step();
        check("R3 steady level no new event", event_rec, 10'h002);
        clear_all();
    endtask

    task automatic t_debug();
        sleeping = 1'b1; sleep_level = 2'd2;
        dbg_pwrup_req = 1'b1;
        step();
        check("R4 dbg rise", event_rec, 10'h010);
        check("R6 R11 dbg wakes level2", wake_req, 1'b1);
        clear_all();
        dbg_pwrup_req = 1'b0;
        step();
        check("R4 dbg fall ignored", event_rec, 10'h000);
        sys_pwrup_req = 1'b1;
        step();
        check("R4 sys rise", event_rec, 10'h020);
        sys_pwrup_req = 1'b0;
        step();
        check("R4 sys fall ignored", event_rec, 10'h020);
        sleeping = 1'b0;
        clear_all();
    endtask

    task automatic t_timer_core();
        tmr_cmp_a = 1'b1; step(); tmr_cmp_a = 1'b0;
        check("R5 compare A", event_rec, 10'h040);
        tmr_cmp_b = 1'b1; step(); tmr_cmp_b = 1'b0;
        check("R5 compare B", event_rec, 10'h0C0);
        tmr_wrap = 1'b1; step(); tmr_wrap = 1'b0;
        check("R5 wrap", event_rec, 10'h1C0);
        sleep_level = 2'd1;
        core_wake_set = 1'b1; step(); core_wake_set = 1'b0;
        check("R5 R6 core wake recorded at level1", event_rec, 10'h3C0);
        check("R10 awake no request", wake_req, 1'b0);
    endtask

    task automatic t_levels();
        // record holds 0x3C0
        sleeping = 1'b1; sleep_level = 2'd0; #1;
        check("R11 level0 core", wake_req, 1'b1);
        sleep_level = 2'd1; #1;
        check("R11 level1 timer", wake_req, 1'b1);
        sleep_level = 2'd2; #1;
        check("R11 level2 neither", wake_req, 1'b0);
        sleep_level = 2'd3; #1;
        check("R11 level3 as level2", wake_req, 1'b0);
        step();
        clr_we = 1'b1; clr_wdata = 10'h200;
        step();
        clr_we = 1'b0; clr_wdata = '0;
        sleep_level = 2'd0; #1;
        check("R11 level0 timer bits ineligible", wake_req, 1'b0);
        sleep_level = 2'd2;
        irq_pin = 1'b1;
        step();
        check("R3 R11 irq at level2", wake_req, 1'b1);
        sleeping = 1'b0; #1;
        check("R10 running suppresses", wake_req, 1'b0);
        sleeping = 1'b1;
    endtask

    task automatic t_mask();
        // record holds 0x1C8, level 2, sleeping
        mask_we = 1'b1; mask_wdata = 10'h3F7;
        step();
        mask_we = 1'b0; mask_wdata = '0;
        check("R9 mask readback", wake_mask, 10'h3F7);
        check("R9 masked irq no wake", wake_req, 1'b0);
        sleep_level = 2'd1; #1;
        check("R9 R10 unmasked timer wakes", wake_req, 1'b1);
        mask_we = 1'b1; mask_wdata = 10'h3FF;
        step();
        mask_we = 1'b0;
        sleep_level = 2'd2; #1;
        check("R9 restored mask wakes", wake_req, 1'b1);
        sleeping = 1'b0;
        clear_all();
        check("R7 cleared", event_rec, 10'h000);
    endtask

    task automatic t_collide();
        irq_pin = ~irq_pin;
        clr_we = 1'b1; clr_wdata = 10'h3FF;
        step();
        clr_we = 1'b0; clr_wdata = '0;
        check("R8 event beats clear", event_rec, 10'h008);
        tmr_wrap = 1'b1;
        clr_we = 1'b1; clr_wdata = 10'h100;
        step();
        tmr_wrap = 1'b0; clr_we = 1'b0; clr_wdata = '0;
        check("R8 pulse beats clear", event_rec, 10'h108);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pins();
        t_debug();
        t_timer_core();
        t_levels();
        t_mask();
        t_collide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule